// File: doc/BRIEF.md
# Store Buffer with Fence Ordering

This block sits between one in-order processor and a single-word memory port. Stores are accepted into a small FIFO of pending writes and drain to memory oldest first. A load whose address misses every pending entry goes to memory ahead of those stores. A load that hits a pending entry takes its data from the youngest matching entry and does not touch memory. A fence is held off until every earlier store has been written, which gives the processor ordering at the points where it asks for it.

The processor side presents one request per cycle, with an opcode, an address and write data, and waits on `req_ready`. Load data returns one cycle after acceptance. The memory side issues at most one access per cycle and completes it when `mem_ready` is high. For reads, the memory supplies `mem_rdata` in the cycle of the handshake.

Top module: `store_buffer_fence`

## Requirements
- R1: After synchronous active-low reset the buffer is empty. `mem_valid` and `rsp_valid` are low, and a store request sees `req_ready` high.
- R2: A store (`req_op` = 2'b01) is accepted when fewer than DEPTH (default 4) entries are pending. With DEPTH entries pending, `req_ready` is low for a store.
- R3: When no memory read is needed, a non-empty buffer presents its oldest entry as a write (`mem_valid`=1, `mem_write`=1). That entry is removed only on a cycle where `mem_ready` is high. Stores reach memory in acceptance order.
- R4: A load (`req_op` = 2'b00) whose address matches no pending entry issues a read (`mem_write`=0, `mem_addr` = load address). This read takes priority over a pending drain. The load is accepted when `mem_ready` is high, and the returned data is the `mem_rdata` of that cycle.
- R5: A load whose address matches one or more pending entries is accepted at once, whatever the state of `mem_ready`. It returns the data of the most recently accepted matching store, and it issues no memory read.
- R6: `rsp_valid` is high for exactly one cycle, the cycle after each load acceptance, and at no other time.
- R7: A fence (`req_op[1]` = 1) sees `req_ready` high only when no store is pending. When it is accepted, every earlier store is in memory. Later requests wait behind the held fence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 00 load, 01 store, 1x fence |
| req_addr | input | AW | Request word address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Request accepted this cycle when valid |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | DW | Load data |
| mem_valid | output | 1 | Memory access requested |
| mem_write | output | 1 | 1 write (drain), 0 read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | DW | Read data, valid in the read handshake cycle |

## Verification
The in-RTL assertions check the following on every cycle: the ring never overflows or underflows, the occupancy count agrees with the entry valid bits, a memory read only appears for a load, a fence is never accepted while a drain is outstanding, and every response pulse follows a load acceptance. Other properties can only be shown by the bench's scenarios against its queue-based model. These are that stores reach memory in program order, that the youngest of several matching entries supplies the forwarded data, that a missing load overtakes a stalled drain, and that memory agrees with every earlier store at the moment a fence completes.

// File: rtl/sb_pkg.sv
// Shared opcode encoding for the store buffer.
// Assumes a two-bit opcode; any opcode with bit 1 set is a fence.
package sb_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_FENCE = 2'b10
    } sb_op_e;
endpackage

// File: rtl/sb_entry_ring.sv
// Circular storage for pending stores: per-slot valid, address and data.
// Assumes DEPTH is a power of two and at least 2, and that the caller never
// pushes when full nor pops when empty.
module sb_entry_ring #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [AW-1:0]         push_addr,
    input  logic [DW-1:0]         push_data,
    input  logic                  pop,
    output logic [DEPTH-1:0]      ent_valid,
    output logic [DEPTH*AW-1:0]   ent_addr_flat,
    output logic [DEPTH*DW-1:0]   ent_data_flat,
    output logic [PW-1:0]         head_ptr,
    output logic [AW-1:0]         head_addr,
    output logic [DW-1:0]         head_data,
    output logic                  empty,
    output logic                  full
);
    logic [DEPTH-1:0] valid_q;
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [PW-1:0]    head_q;
    logic [PW-1:0]    tail_q;
    logic [CW-1:0]    count_q;

    // Advance head on drain, tail on store, and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= tail_q + 1'b1;
            if (pop)  head_q <= head_q + 1'b1;
            if (push && !pop)      count_q <= count_q + 1'b1;
            else if (pop && !push) count_q <= count_q - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Fill a slot at the tail, release it at the head.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                addr_q[g]  <= '0;
                data_q[g]  <= '0;
            end else if (push && tail_q == PW'(g)) begin
                valid_q[g] <= 1'b1;
                addr_q[g]  <= push_addr;
                data_q[g]  <= push_data;
            end else if (pop && head_q == PW'(g)) begin
                valid_q[g] <= 1'b0;
            end
        end
        assign ent_addr_flat[g*AW +: AW] = addr_q[g];
        assign ent_data_flat[g*DW +: DW] = data_q[g];
    end

    assign ent_valid = valid_q;
    assign head_ptr  = head_q;
    assign head_addr = addr_q[head_q];
    assign head_data = data_q[head_q];
    assign empty     = (count_q == '0);
    assign full      = (count_q == CW'(DEPTH));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R2
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(valid_q) == int'(count_q));
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/sb_fwd_select.sv
// Store-to-load forwarding: finds the youngest valid entry whose address
// equals the lookup address. Assumes entries are aged from head_ptr.
module sb_fwd_select #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]    ent_valid,
    input  logic [DEPTH*AW-1:0] ent_addr_flat,
    input  logic [DEPTH*DW-1:0] ent_data_flat,
    input  logic [PW-1:0]       head_ptr,
    input  logic [AW-1:0]       lookup_addr,
    output logic                hit,
    output logic [DW-1:0]       hit_data
);
    // Walk oldest to youngest so the last match, the youngest, wins.
    always_comb begin
        logic [PW-1:0] idx;
        hit      = 1'b0;
        hit_data = '0;
        for (int a = 0; a < DEPTH; a++) begin
            idx = head_ptr + PW'(a);
            if (ent_valid[idx] && ent_addr_flat[idx*AW +: AW] == lookup_addr) begin
                hit      = 1'b1;
                hit_data = ent_data_flat[idx*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/sb_port_arb.sv
// Decides per cycle which request is accepted and what the memory port does.
// Assumes a missing load's read outranks a drain and a fence waits for empty.
module sb_port_arb
    import sb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic          fwd_hit,
    input  logic          empty,
    input  logic          full,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic          mem_ready,
    output logic          req_ready,
    output logic          push,
    output logic          pop,
    output logic          load_take,
    output logic          load_from_mem,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    logic is_load, is_store, is_fence, rd_needed;

    // Classify the request and find out whether memory must be read.
    always_comb begin
        is_load   = req_valid && (req_op == OP_LOAD);
        is_store  = req_valid && (req_op == OP_STORE);
        is_fence  = req_valid && req_op[1];
        rd_needed = is_load && !fwd_hit;
    end

    // Drive the memory port: a needed read first, else the oldest store.
    always_comb begin
        mem_valid = rd_needed || !empty;
        mem_write = !rd_needed && !empty;
        mem_addr  = rd_needed ? req_addr : head_addr;
        mem_wdata = head_data;
    end

    // Readiness per opcode and the resulting buffer and response strobes.
    always_comb begin
        if (req_op[1])              req_ready = empty;
        else if (req_op == OP_LOAD) req_ready = fwd_hit || mem_ready;
        else                        req_ready = !full;
        push          = is_store && !full;
        pop           = mem_write && mem_ready;
        load_take     = is_load && (fwd_hit || mem_ready);
        load_from_mem = rd_needed && mem_ready;
    end

    // R4
    read_is_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_write) |-> (req_valid && req_op == OP_LOAD));
    // R7
    fence_no_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_fence && req_ready) |-> !(mem_valid && mem_write));
endmodule

// File: rtl/store_buffer_fence.sv
// Store buffer between one processor and one memory port with forwarding
// and fence ordering. Assumes one request per cycle and single-word accesses;
// memory read data arrives in the read handshake cycle.
module store_buffer_fence
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata
);
    logic [DEPTH-1:0]    ent_valid;
    logic [DEPTH*AW-1:0] ent_addr_flat;
    logic [DEPTH*DW-1:0] ent_data_flat;
    logic [PW-1:0]       head_ptr;
    logic [AW-1:0]       head_addr;
    logic [DW-1:0]       head_data;
    logic                empty, full, fwd_hit;
    logic [DW-1:0]       fwd_data;
    logic                push, pop, load_take, load_from_mem;

    sb_entry_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(req_addr), .push_data(req_wdata), .pop(pop),
        .ent_valid(ent_valid), .ent_addr_flat(ent_addr_flat),
        .ent_data_flat(ent_data_flat), .head_ptr(head_ptr),
        .head_addr(head_addr), .head_data(head_data),
        .empty(empty), .full(full)
    );

    sb_fwd_select #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
        .ent_valid(ent_valid), .ent_addr_flat(ent_addr_flat),
        .ent_data_flat(ent_data_flat), .head_ptr(head_ptr),
        .lookup_addr(req_addr), .hit(fwd_hit), .hit_data(fwd_data)
    );

    sb_port_arb #(.AW(AW), .DW(DW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .fwd_hit(fwd_hit), .empty(empty), .full(full),
        .head_addr(head_addr), .head_data(head_data), .mem_ready(mem_ready),
        .req_ready(req_ready), .push(push), .pop(pop),
        .load_take(load_take), .load_from_mem(load_from_mem),
        .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // Register load data: forwarded entry on a hit, memory data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= load_take;
            if (load_take) rsp_rdata <= load_from_mem ? mem_rdata : fwd_data;
        end
    end

    // R6
    rsp_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_op == OP_LOAD && req_ready));
    // R5
    hit_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_LOAD && fwd_hit) |-> !(mem_valid && !mem_write));
endmodule

// File: tb/tb_store_buffer_fence.sv
module tb_store_buffer_fence;
    localparam int DEPTH = 4;
    localparam int AW    = 4;
    localparam int DW    = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          req_ready, rsp_valid, mem_valid, mem_write, mem_ready;
    logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;

    always #2.5 clk = ~clk;

    store_buffer_fence #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } ent_t;
    ent_t          q[$];
    logic [DW-1:0] bmem [16];
    logic [DW-1:0] arch [16];
    int            total = 0, fails = 0;
    int            rdy_mode = 0;
    logic [15:0]   lfsr = 16'hACE1;
    logic          exp_rsp_v = 1'b0;
    logic [DW-1:0] exp_rsp_d = '0;
    string         exp_rsp_tag = "R4";

    assign mem_rdata = bmem[mem_addr];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock of stimulus, model prediction and comparison.
    task automatic cycle(input logic v, input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic acc);
        logic hit, e_rdy, e_mv, e_mw, is_ld;
        logic [DW-1:0] fd;
        int n;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        req_valid = v; req_op = op; req_addr = a; req_wdata = d;
        mem_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : (lfsr[0] | lfsr[5]);
        #1;
        chk("R6 rsp_valid", 32'(rsp_valid), 32'(exp_rsp_v));
        if (exp_rsp_v) chk({exp_rsp_tag, " rsp_rdata"}, 32'(rsp_rdata), 32'(exp_rsp_d));
        hit = 1'b0; fd = '0; n = q.size();
        foreach (q[i]) if (q[i].a == a) begin hit = 1'b1; fd = q[i].d; end
        is_ld = v && op == 2'b00;
        if (op[1])           e_rdy = (n == 0);
        else if (op == 2'b00) e_rdy = hit || mem_ready;
        else                 e_rdy = (n < DEPTH);
        e_mv = (is_ld && !hit) || n > 0;
        e_mw = !(is_ld && !hit) && n > 0;
        if (v) chk(op[1] ? "R7 fence ready" : (op == 2'b00 ? (hit ? "R5 load ready" : "R4 load ready")
                                                           : "R2 store ready"),
                   32'(req_ready), 32'(e_rdy));
        chk("R3 mem_valid", 32'(mem_valid), 32'(e_mv));
        if (e_mv) begin
            chk("R4 mem_write", 32'(mem_write), 32'(e_mw));
            chk(e_mw ? "R3 drain addr" : "R4 read addr", 32'(mem_addr), e_mw ? 32'(q[0].a) : 32'(a));
            if (e_mw) chk("R3 drain data", 32'(mem_wdata), 32'(q[0].d));
        end
        acc = v && e_rdy;
        @(posedge clk); #1;
        exp_rsp_v = acc && is_ld;
        if (exp_rsp_v) begin
            exp_rsp_d   = hit ? fd : bmem[a];
            exp_rsp_tag = hit ? "R5" : "R4";
        end
        if (e_mv && e_mw && mem_ready) begin
            bmem[q[0].a] = q[0].d;
            void'(q.pop_front());
        end
        if (acc && !op[1] && op[0]) begin
            q.push_back('{a: a, d: d});
            arch[a] = d;
        end
        if (acc && op[1])
            for (int k = 0; k < 16; k++) chk("R7 memory at fence", 32'(bmem[k]), 32'(arch[k]));
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic acc;
        do cycle(1'b1, op, a, d, acc); while (!acc);
    endtask

    task automatic idle(input int n);
        logic acc;
        for (int i = 0; i < n; i++) cycle(1'b0, 2'b00, '0, '0, acc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        logic acc;
        for (int k = 0; k < 16; k++) begin bmem[k] = 16'(k * 16'h0101); arch[k] = bmem[k]; end
        rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_wdata = '0; mem_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: empty and quiet after reset, store would be accepted
        chk("R1 mem_valid", 32'(mem_valid), 0);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        req_valid = 1'b1; req_op = 2'b01; #1;
        chk("R1 store ready", 32'(req_ready), 1);
        req_valid = 1'b0;
        @(negedge clk);

        // R3 R4: stores drain with memory ready, loads miss and hit
        issue(2'b01, 4'd1, 16'h1111);
        issue(2'b01, 4'd2, 16'h2222);
        issue(2'b00, 4'd5, '0);
        issue(2'b00, 4'd1, '0);
        idle(3);

        // R2 R5: fill while memory stalls, probe full and youngest forwarding
        rdy_mode = 1;
        issue(2'b01, 4'd3, 16'h0011);
        issue(2'b01, 4'd3, 16'h0022);
        issue(2'b01, 4'd7, 16'h0033);
        issue(2'b01, 4'd3, 16'h0044);
        for (int i = 0; i < 3; i++) cycle(1'b1, 2'b01, 4'd9, 16'h0999, acc);
        issue(2'b00, 4'd3, '0);
        issue(2'b00, 4'd7, '0);
        for (int i = 0; i < 2; i++) cycle(1'b1, 2'b00, 4'd8, '0, acc);
        for (int i = 0; i < 2; i++) cycle(1'b1, 2'b10, 4'd0, '0, acc);
        // R4 read overtakes the stalled drains, then R7 fence waits for empty
        rdy_mode = 0;
        issue(2'b00, 4'd8, '0);
        issue(2'b10, 4'd0, '0);
        issue(2'b00, 4'd3, '0);
        idle(2);

        // Mixed traffic with irregular memory readiness
        rdy_mode = 2;
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 5)      issue(2'b01, 4'($urandom_range(0, 7)), 16'($urandom));
            else if (r < 8) issue(2'b00, 4'($urandom_range(0, 7)), '0);
            else if (r < 9) issue(2'b10, 4'd0, '0);
            else            idle(1);
        end
        issue(2'b10, 4'd0, '0);
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end
endmodule